// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. It runs directly on the incoming bit clock. On each rising bit-clock edge it samples the frame clock and the data line. It supports four framings, chosen by a two-bit control input: I2S, left-justified, right-justified and a DSP style in which a short frame-clock pulse starts each word. Word length is 16, 20 or 24 bits and is chosen by a second control input. Each received word is sign-extended to 24 bits.

Completed left/right pairs appear on two 24-bit outputs together with a one-cycle valid strobe. The strobe is in the bit-clock domain. Moving the samples into any other clock domain is left to the logic that follows. The bit clock may stop between bits, so bursty or gated clocks work. After reset the receiver stays idle until it samples a rising frame-clock edge, and it aligns its channels from that edge.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst` is high, and on the first bit-clock edge after `rst` falls, `valid_o` is 0 and both sample outputs are 0.
- R2: After reset no word is captured until a rising frame-clock edge has been sampled. With the frame clock held low no strobe ever appears, whatever arrives on `sdata`.
- R3: `fmt` = 00 selects I2S framing. The frame clock low marks the left channel. The MSB is sampled on the first bit clock after the frame-clock transition, and the next N-1 bits follow it.
- R4: `fmt` = 11 selects left-justified framing. The frame clock high marks the left channel. The MSB is sampled on the same bit clock that first sees the new frame-clock level.
- R5: `fmt` = 01 selects right-justified framing. The frame clock high marks the left channel. The word's LSB is the last bit before the frame-clock transition, and the N bits ending there form the word. Any earlier bits in the half-frame are ignored. The word is taken at the transition that closes its half-frame.
- R6: `fmt` = 10 selects DSP framing. Each sampled rising edge of the frame clock starts a word, with the MSB on that bit, and falling edges are ignored. Words alternate left, right, left, starting with left on the first word after the rising edge that starts the receiver.
- R7: `wsel` sets N. 00 gives 24 bits, 01 gives 20 bits, and 10 or 11 give 16 bits. Bit N-1 of a word is copied into output bits 23 down to N.
- R8: `valid_o` is high for exactly one bit-clock cycle per stereo pair. It is raised on the edge after the right word of the pair is captured. At that point `left_o` holds the left word that came before it. A right word with no left word before it since the start produces no strobe.
- R9: Only rising bit-clock edges matter. Pauses of any length in the bit clock, inside or between words, do not change the samples received.
- R10: Data bits outside the N-bit word in a half-frame or DSP slot have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrclk | input | 1 | Frame clock (channel select, or word-start pulse in DSP framing) |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| fmt | input | 2 | Framing: 00 I2S, 01 right-justified, 10 DSP, 11 left-justified |
| wsel | input | 2 | Word length: 00 = 24, 01 = 20, 1x = 16 bits |
| left_o | output | 24 | Sign-extended left sample of the latest pair |
| right_o | output | 24 | Sign-extended right sample of the latest pair |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
A bit counter that is off by one shows up at the next strobe as a sample shifted by one place: the value is doubled or halved, and a pad bit or the neighbour's LSB enters at one end. A wrong channel flag or a wrong arming state shows up as swapped channels, or as too many or too few strobes within the first two frames. The bench fills every unused bit slot with ones, so a word boundary that slips even by one bit changes the sample that is delivered. It checks each delivered pair against the frame that was sent, in every framing and every width, with and without clock pauses.

// File: rtl/audio_serial_rx_pkg.sv
package audio_serial_rx_pkg;

  localparam int SMP_W = 24;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_DSP = 2'b10,
    FMT_LJ  = 2'b11
  } fmt_e;

  // word length in bits for a width code
  function automatic logic [4:0] word_len(input logic [1:0] code);
    case (code)
      2'b00:   word_len = 5'd24;
      2'b01:   word_len = 5'd20;
      default: word_len = 5'd16;
    endcase
  endfunction

  // replicate bit N-1 of the low N bits into the upper bits
  function automatic logic [SMP_W-1:0] widen(input logic [SMP_W-1:0] raw,
                                             input logic [1:0] code);
    case (code)
      2'b00:   widen = raw;
      2'b01:   widen = {{4{raw[19]}}, raw[19:0]};
      default: widen = {{8{raw[15]}}, raw[15:0]};
    endcase
  endfunction

endpackage

// File: rtl/asr_frame_track.sv
module asr_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic lrclk,
  input  logic dsp_mode,
  output logic lr_prev,
  output logic edge_det,
  output logic en
);
  logic lr_q;
  logic armed_q;
  logic rise;

  assign rise     = lrclk & ~lr_q;
  assign edge_det = dsp_mode ? rise : (lrclk ^ lr_q);
  assign en       = armed_q | rise;
  assign lr_prev  = lr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q    <= 1'b1;   // a low level must be seen before a rise counts
      armed_q <= 1'b0;
    end else begin
      lr_q <= lrclk;
      if (rise) armed_q <= 1'b1;
    end
  end

  // R2: once armed, stays armed until reset
  a_r2_arm_sticky: assert property (@(posedge clk) disable iff (rst)
    armed_q |=> armed_q);

  // R2: arming only follows a high frame-clock sample
  a_r2_arm_after_high: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(lrclk));

endmodule

// File: rtl/asr_bit_shift.sv
module asr_bit_shift #(
  parameter int W     = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdata,
  input  logic             edge_det,
  output logic [CNT_W-1:0] pos,
  output logic [W-1:0]     hist,
  output logic [W-1:0]     word_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     sh_q;

  assign pos      = edge_det ? '0 : cnt_q;
  assign hist     = sh_q;
  assign word_now = {sh_q[W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      sh_q  <= word_now;
      cnt_q <= (pos == CNT_MAX) ? CNT_MAX : pos + 1'b1;
    end
  end

  // R9: a long half-frame parks the counter instead of wrapping it
  a_r9_cnt_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == 1));

endmodule

// File: rtl/asr_pair_assembler.sv
module asr_pair_assembler
  import audio_serial_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wsel,
  input  logic             lrclk,
  input  logic             lr_prev,
  input  logic             edge_det,
  input  logic [CNT_W-1:0] pos,
  input  logic [SMP_W-1:0] hist,
  input  logic [SMP_W-1:0] word_now,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             valid_o
);
  logic [4:0]       nb;
  logic             cap;
  logic             is_left;
  logic [SMP_W-1:0] raw;
  logic [SMP_W-1:0] ext;
  logic [SMP_W-1:0] hold_l;
  logic             have_l;
  logic             dsp_right_q;

  assign nb = word_len(wsel);

  always_comb begin
    case (fmt_e'(fmt))
      FMT_I2S: begin
        cap     = (pos == CNT_W'(nb));
        raw     = word_now;
        is_left = ~lrclk;
      end
      FMT_LJ: begin
        cap     = (pos == CNT_W'(nb - 5'd1));
        raw     = word_now;
        is_left = lrclk;
      end
      FMT_DSP: begin
        cap     = (pos == CNT_W'(nb - 5'd1));
        raw     = word_now;
        is_left = ~dsp_right_q;
      end
      default: begin // right-justified: word closes at the transition
        cap     = edge_det;
        raw     = hist;
        is_left = lr_prev;
      end
    endcase
    cap = cap & en;
  end

  assign ext = widen(raw, wsel);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      hold_l      <= '0;
      have_l      <= 1'b0;
      dsp_right_q <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap && fmt_e'(fmt) == FMT_DSP) dsp_right_q <= ~dsp_right_q;
      if (cap) begin
        if (is_left) begin
          hold_l <= ext;
          have_l <= 1'b1;
        end else if (have_l) begin
          left_o  <= hold_l;
          right_o <= ext;
          valid_o <= 1'b1;
          have_l  <= 1'b0;
        end
      end
    end
  end

  // R8: strobe never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8: a right word without a pending left word gives no strobe
  a_r8_needs_left: assert property (@(posedge clk) disable iff (rst)
    (cap && !is_left && !have_l) |=> !valid_o);

  // R2: nothing is delivered before the receiver is armed
  a_r2_quiet_unarmed: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid_o);

  // R6: DSP channel flips on every captured word
  a_r6_dsp_alternate: assert property (@(posedge clk) disable iff (rst)
    (cap && fmt_e'(fmt) == FMT_DSP) |=> (dsp_right_q != $past(dsp_right_q)));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_serial_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        bclk,
  input  logic        rst,
  input  logic        lrclk,
  input  logic        sdata,
  input  logic [1:0]  fmt,
  input  logic [1:0]  wsel,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  logic             lr_prev;
  logic             edge_det;
  logic             en;
  logic [CNT_W-1:0] pos;
  logic [SMP_W-1:0] hist;
  logic [SMP_W-1:0] word_now;

  asr_frame_track u_track (
    .clk      (bclk),
    .rst      (rst),
    .lrclk    (lrclk),
    .dsp_mode (fmt == FMT_DSP),
    .lr_prev  (lr_prev),
    .edge_det (edge_det),
    .en       (en)
  );

  asr_bit_shift #(.W(SMP_W), .CNT_W(CNT_W)) u_shift (
    .clk      (bclk),
    .rst      (rst),
    .sdata    (sdata),
    .edge_det (edge_det),
    .pos      (pos),
    .hist     (hist),
    .word_now (word_now)
  );

  asr_pair_assembler #(.CNT_W(CNT_W)) u_pair (
    .clk      (bclk),
    .rst      (rst),
    .en       (en),
    .fmt      (fmt),
    .wsel     (wsel),
    .lrclk    (lrclk),
    .lr_prev  (lr_prev),
    .edge_det (edge_det),
    .pos      (pos),
    .hist     (hist),
    .word_now (word_now),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

endmodule

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  logic        clk = 1'b0;
  logic        clk_run = 1'b1;
  logic        rst = 1'b1;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [1:0]  wsel = 2'b00;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  int np = 0;
  int dbl = 0;
  logic prev_v = 1'b0;
  logic [23:0] pl [8];
  logic [23:0] pr [8];
  logic [23:0] fl [4];
  logic [23:0] fr [4];

  audio_serial_rx uut (
    .bclk(clk), .rst(rst), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wsel(wsel),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  // 50 MHz; a pause always parks the clock low
  initial forever begin
    #10;
    if (clk_run || clk) clk = ~clk;
  end

  always @(negedge clk) begin
    if (valid_o) begin
      if (np < 8) begin
        pl[np] = left_o;
        pr[np] = right_o;
      end
      np = np + 1;
      if (prev_v) dbl = dbl + 1;
    end
    prev_v = valid_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int wlen(input logic [1:0] c);
    return (c == 2'b00) ? 24 : (c == 2'b01) ? 20 : 16;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    logic signed [23:0] t;
    t = v << (24 - n);
    return 24'(t >>> (24 - n));
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    lrclk = 1'b0;
    sdata = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    np = 0;
    dbl = 0;
  endtask

  task automatic send_frame(input logic [1:0] f, input int n,
                            input logic [23:0] l, input logic [23:0] r,
                            input bit burst);
    for (int h = 0; h < 2; h++) begin
      for (int b = 0; b < 32; b++) begin
        logic [23:0] w;
        logic bv;
        logic lv;
        w = (h == 0) ? l : r;
        bv = 1'b1; // pad bits are ones
        case (f)
          2'b00: begin lv = (h == 1); if (b >= 1 && b <= n) bv = w[n-b]; end
          2'b11: begin lv = (h == 0); if (b < n) bv = w[n-1-b]; end
          2'b01: begin lv = (h == 0); if (b >= 32 - n) bv = w[31-b]; end
          default: begin lv = (b == 0); if (b < n) bv = w[n-1-b]; end
        endcase
        @(negedge clk);
        lrclk = lv;
        sdata = bv;
        if (burst && (b == 7 || b == 20)) begin
          clk_run = 1'b0;
          #170;
          clk_run = 1'b1;
        end
      end
    end
  endtask

  // four frames; checks every pair that must be delivered
  task automatic run_stream(input logic [1:0] f, input logic [1:0] w,
                            input bit burst, input string req);
    int n;
    int first;
    int cnt;
    n = wlen(w);
    fmt = f;
    wsel = w;
    do_reset();
    for (int k = 0; k < 4; k++) send_frame(f, n, fl[k], fr[k], burst);
    repeat (4) @(negedge clk);
    lrclk = 1'b0;
    sdata = 1'b0;
    repeat (40) @(negedge clk);
    first = (f == 2'b00) ? 1 : 0;          // I2S arms inside frame 0
    cnt = 4 - first - ((f == 2'b01) ? 1 : 0); // RJ delivers at next edge
    chk(np == cnt, req, "pair count", 24'(np), 24'(cnt));
    chk(dbl == 0, "R8", "strobe longer than one cycle", 24'(dbl), 24'd0);
    for (int k = 0; k < cnt && k < 8; k++) begin
      chk(pl[k] == sx(fl[first+k], n), req, "left sample", pl[k], sx(fl[first+k], n));
      chk(pr[k] == sx(fr[first+k], n), req, "right sample", pr[k], sx(fr[first+k], n));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R1", "valid in reset", 24'(valid_o), 24'd0);
    chk(left_o == 24'd0, "R1", "left in reset", left_o, 24'd0);
    chk(right_o == 24'd0, "R1", "right in reset", right_o, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0 && left_o == 0, "R1", "first cycle after reset", left_o, 24'd0);
  endtask

  task automatic t_no_rise();
    fmt = 2'b11;
    wsel = 2'b10;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      lrclk = 1'b0;
      sdata = (i % 3) == 0;
    end
    repeat (4) @(negedge clk);
    chk(np == 0, "R2", "strobes without a rising frame edge", 24'(np), 24'd0);
  endtask

  task automatic set_vals(input logic [23:0] a0, input logic [23:0] b0,
                          input logic [23:0] a1, input logic [23:0] b1,
                          input logic [23:0] a2, input logic [23:0] b2,
                          input logic [23:0] a3, input logic [23:0] b3);
    fl[0] = a0; fr[0] = b0; fl[1] = a1; fr[1] = b1;
    fl[2] = a2; fr[2] = b2; fl[3] = a3; fr[3] = b3;
  endtask

  initial begin
    #(200000 * 20);
    n_chk = n_chk + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();                                                   // R1
    t_no_rise();                                                 // R2
    set_vals(24'h123456, 24'h800001, 24'h7FFFFE, 24'hA5A5A5,
             24'h000001, 24'hFFFFFF, 24'h3C3C3C, 24'hC0FFEE);
    run_stream(2'b00, 2'b00, 1'b0, "R3");                        // I2S 24
    set_vals(24'h0ABCDE, 24'h080000, 24'h7FFFF, 24'h00001,
             24'h55555, 24'hAAAAA, 24'h00000, 24'hFFFFF);
    run_stream(2'b11, 2'b01, 1'b0, "R4");                        // LJ 20, R7
    set_vals(24'h1234, 24'h8000, 24'h7FFF, 24'hFEDC,
             24'h0001, 24'h4242, 24'hBEEF, 24'h0000);
    run_stream(2'b01, 2'b11, 1'b0, "R5");                        // RJ 16 via code 11, R10
    set_vals(24'h800000, 24'h000123, 24'h654321, 24'hFEDCBA,
             24'h111111, 24'h7F0000, 24'h00FF00, 24'h999999);
    run_stream(2'b01, 2'b00, 1'b0, "R5");                        // RJ 24
    set_vals(24'h0F0F, 24'hF0F0, 24'h8001, 24'h7FFE,
             24'h1111, 24'h2222, 24'h3333, 24'hCCCC);
    run_stream(2'b10, 2'b10, 1'b0, "R6");                        // DSP 16
    set_vals(24'h0ABCDE, 24'h812345, 24'h00FFFF, 24'hFF0000,
             24'h2468AC, 24'hDB9753, 24'h000002, 24'h400000);
    run_stream(2'b10, 2'b00, 1'b0, "R6");                        // DSP 24
    set_vals(24'h8421, 24'h1248, 24'hFFFF, 24'h0001,
             24'h7000, 24'h9000, 24'h0F00, 24'hF00F);
    run_stream(2'b11, 2'b10, 1'b1, "R9");                        // LJ 16, paused clock
    set_vals(24'h80000, 24'h7FFFF, 24'h13579, 24'h2468A,
             24'hFFFFE, 24'h00010, 24'hABCDE, 24'h54321);
    run_stream(2'b00, 2'b01, 1'b1, "R9");                        // I2S 20, paused clock, R7
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule